// File: doc/BRIEF.md
# Bit-Slice 32-bit Integer ALU

This block is a purely combinational integer arithmetic and logic unit for a datapath. It takes two 32-bit operands and a 4-bit operation code. It produces a 32-bit result, a zero flag, a signed-overflow flag and the carry out of the top bit.

The datapath is a chain of identical one-bit slices that ripple a carry from bit 0 upwards. Each slice can invert its A bit, invert its B bit, and pick one of four sources: AND, OR, the adder sum, or a less-than input.

- Subtraction inverts B and feeds a carry of 1 into bit 0. Both come from a single negate-B control.
- NOR is the AND path with both operands inverted.
- Set-on-less-than takes a sign bit from the top slice, corrected by the overflow flag, and routes it to the less-than input of bit 0. Every other slice has that input tied low.

A small decoder turns the operation code into the slice controls: invert-A, negate-B and a source pick. There is no clock, no reset and no internal state. Every output settles from the current inputs.

Top module: `bitslice_alu`

## Requirements
- R1: Code 4'b0000 gives Result = A AND B, bit by bit.
- R2: Code 4'b0001 gives Result = A OR B, bit by bit.
- R3: Code 4'b0010 gives Result = (A + B) mod 2^32.
- R4: Code 4'b0110 gives Result = (A - B) mod 2^32.
- R5: Code 4'b0111 gives Result = 1 when A < B as two's-complement numbers and 0 otherwise. Result bits 31..1 are always 0. The answer stays correct when A - B overflows.
- R6: Code 4'b1100 gives Result = NOT (A OR B).
- R7: CarryOut is the carry out of bit 31 of the internal sum X + Y + n. Here n = 1 for codes 0110, 0111 and 1100 and n = 0 otherwise. Y = B XOR {32{n}}. X = NOT A for code 1100 and X = A otherwise.
- R8: Overflow is 1 exactly when that internal sum overflows as a signed addition: X and Y have the same sign bit and the 32-bit sum has the other sign.
- R9: Zero is 1 exactly when all 32 Result bits are 0. When all inputs are zero under code 0000, Result is 0, Zero is 1 and both other flags are 0.
- R10: Any other code (for example 4'b0011 or 4'b1111) gives Result = 0 and Zero = 1. CarryOut and Overflow follow R7/R8 with n = 0 and X = A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| op_code | input | 4 | Operation select |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of the internal addition |
| carry_out | output | 1 | Carry out of bit 31 |

## Verification
Set-on-less-than and signed overflow resolve together: the less-than bit is the adder sign corrected by the overflow flag, both from the same subtraction. The bench provokes this with operand pairs whose difference leaves the 32-bit signed range, such as the most negative value against 1 and the most positive value against -1. It also uses pairs that stay in range. Each result is judged against a signed comparison computed in the bench. The overflow flag is judged against a sign-rule model of the same subtraction.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0110,
        OP_SLT = 4'b0111,
        OP_NOR = 4'b1100
    } alu_op_e;

    typedef enum logic [1:0] {
        PICK_AND  = 2'd0,
        PICK_OR   = 2'd1,
        PICK_SUM  = 2'd2,
        PICK_LESS = 2'd3
    } pick_e;

    typedef struct packed {
        logic  inv_a;
        logic  neg_b;
        pick_e pick;
        logic  legal;
    } slice_ctl_t;

endpackage

// File: rtl/alu_decode.sv
`timescale 1ns/1ps
module alu_decode
    import alu_pkg::*;
(
    input  logic [3:0] op_code,
    output slice_ctl_t ctl
);

    always_comb begin
        ctl = '{inv_a: 1'b0, neg_b: 1'b0, pick: PICK_AND, legal: 1'b1};
        unique case (op_code)
            OP_AND: ctl.pick = PICK_AND;
            OP_OR:  ctl.pick = PICK_OR;
            OP_ADD: ctl.pick = PICK_SUM;
            OP_SUB: begin
                ctl.neg_b = 1'b1;
                ctl.pick  = PICK_SUM;
            end
            OP_SLT: begin
                ctl.neg_b = 1'b1;
                ctl.pick  = PICK_LESS;
            end
            OP_NOR: begin
                ctl.inv_a = 1'b1;
                ctl.neg_b = 1'b1;
                ctl.pick  = PICK_AND;
            end
            default: ctl.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_slice.sv
`timescale 1ns/1ps
module alu_slice
    import alu_pkg::*;
(
    input  logic  a_bit,
    input  logic  b_bit,
    input  logic  carry_in,
    input  logic  less_in,
    input  logic  inv_a,
    input  logic  neg_b,
    input  pick_e pick,
    output logic  sum_bit,
    output logic  carry_nx,
    output logic  res_bit
);

    logic a_eff, b_eff;

    always_comb begin
        a_eff    = a_bit ^ inv_a;
        b_eff    = b_bit ^ neg_b;
        sum_bit  = a_eff ^ b_eff ^ carry_in;
        carry_nx = (a_eff & b_eff) | (a_eff & carry_in) | (b_eff & carry_in);
        unique case (pick)
            PICK_AND:  res_bit = a_eff & b_eff;
            PICK_OR:   res_bit = a_eff | b_eff;
            PICK_SUM:  res_bit = sum_bit;
            PICK_LESS: res_bit = less_in;
            default:   res_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/bitslice_alu.sv
`timescale 1ns/1ps
module bitslice_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [3:0]       op_code,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             overflow,
    output logic             carry_out
);

    localparam int MSB = WIDTH - 1;

    slice_ctl_t       ctl;
    logic [WIDTH-1:0] raw_res;
    logic             set_bit;

    alu_decode u_dec (
        .op_code (op_code),
        .ctl     (ctl)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic cin_w, cout_w, sum_w, res_w, less_w;
        if (i == 0) begin : g_lsb
            assign cin_w  = ctl.neg_b;
            assign less_w = set_bit;
        end else begin : g_rest
            assign cin_w  = g_bit[i-1].cout_w;
            assign less_w = 1'b0;
        end
        alu_slice u_slice (
            .a_bit    (opnd_a[i]),
            .b_bit    (opnd_b[i]),
            .carry_in (cin_w),
            .less_in  (less_w),
            .inv_a    (ctl.inv_a),
            .neg_b    (ctl.neg_b),
            .pick     (ctl.pick),
            .sum_bit  (sum_w),
            .carry_nx (cout_w),
            .res_bit  (res_w)
        );
        assign raw_res[i] = res_w;
    end

    assign carry_out = g_bit[MSB].cout_w;
    assign overflow  = g_bit[MSB].cin_w ^ g_bit[MSB].cout_w;
    assign set_bit   = g_bit[MSB].sum_w ^ overflow;
    assign result    = ctl.legal ? raw_res : '0;
    assign zero      = ~|result;

    always_comb begin
        // R10
        undef_zero_chk: assert (ctl.legal || (result == '0 && zero));
        if (op_code == OP_SLT) begin
            // R5
            slt_upper_chk: assert (result[MSB:1] == '0);
        end
        if (op_code == OP_NOR) begin
            // R6
            nor_path_chk: assert (result == ~(opnd_a | opnd_b));
        end
        if (op_code == OP_SUB) begin
            // R4
            sub_value_chk: assert (result == opnd_a - opnd_b);
        end
        if (op_code == OP_ADD && overflow) begin
            // R8
            add_ovf_chk: assert (opnd_a[MSB] == opnd_b[MSB] && result[MSB] != opnd_a[MSB]);
        end
    end

endmodule

// File: tb/test_bitslice_alu.sv
`timescale 1ns/1ps
module test_bitslice_alu;

    logic        clk = 1'b0;
    logic [31:0] a, b, res;
    logic [3:0]  op;
    logic        zf, of, cf;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    bitslice_alu i_bitslice_alu (
        .opnd_a(a), .opnd_b(b), .op_code(op),
        .result(res), .zero(zf), .overflow(of), .carry_out(cf)
    );

    // {op, a, b, expected result}
    localparam logic [99:0] VEC [13] = '{
        {4'b0000, 32'hF0F0_1234, 32'h0FF0_FF00, 32'h00F0_1200},
        {4'b0001, 32'hF000_000F, 32'h0F00_00F0, 32'hFF00_00FF},
        {4'b0010, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000},
        {4'b0010, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000},
        {4'b0110, 32'h0000_0005, 32'h0000_0007, 32'hFFFF_FFFE},
        {4'b0110, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF},
        {4'b0111, 32'h8000_0000, 32'h0000_0001, 32'h0000_0001},
        {4'b0111, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000},
        {4'b0111, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'h0000_0001},
        {4'b0111, 32'h0000_0003, 32'h0000_0003, 32'h0000_0000},
        {4'b1100, 32'h0F0F_0000, 32'h00FF_0000, 32'hF000_FFFF},
        {4'b0011, 32'h1234_5678, 32'h0000_0001, 32'h0000_0000},
        {4'b1111, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    function automatic string tag_of(input logic [3:0] o);
        case (o)
            4'b0000: return "R1";
            4'b0001: return "R2";
            4'b0010: return "R3";
            4'b0110: return "R4";
            4'b0111: return "R5";
            4'b1100: return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic model(input logic [3:0] o, input logic [31:0] x_in, input logic [31:0] y_in,
                         output logic [31:0] r, output logic c, output logic v);
        logic        n, ia;
        logic [31:0] x, y;
        logic [32:0] s;
        n  = (o == 4'b0110 || o == 4'b0111 || o == 4'b1100);
        ia = (o == 4'b1100);
        x  = ia ? ~x_in : x_in;
        y  = n ? ~y_in : y_in;
        s  = {1'b0, x} + {1'b0, y} + {32'd0, n};
        c  = s[32];
        v  = (x[31] == y[31]) && (s[31] != x[31]);
        case (o)
            4'b0000: r = x_in & y_in;
            4'b0001: r = x_in | y_in;
            4'b0010: r = x_in + y_in;
            4'b0110: r = x_in - y_in;
            4'b0111: r = ($signed(x_in) < $signed(y_in)) ? 32'd1 : 32'd0;
            4'b1100: r = ~(x_in | y_in);
            default: r = 32'd0;
        endcase
    endtask

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s op=%b a=%h b=%h actual=%h expected=%h", rq, what, op, a, b, act, exp);
        end
    endtask

    task automatic apply_and_check(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                                   input bit use_exp, input logic [31:0] exp_tab);
        logic [31:0] r;
        logic        c, v;
        @(posedge clk);
        op = o; a = x; b = y;
        @(negedge clk);
        model(o, x, y, r, c, v);
        chk(tag_of(o), "result", res, use_exp ? exp_tab : r);
        chk("R9", "zero", {31'd0, zf}, {31'd0, (use_exp ? exp_tab : r) == 32'd0});
        chk("R8", "overflow", {31'd0, of}, {31'd0, v});
        chk("R7", "carry_out", {31'd0, cf}, {31'd0, c});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        op = 4'b0000; a = '0; b = '0;
        @(negedge clk);
        // R9: idle state with all-zero inputs
        chk("R9", "idle result", res, 32'd0);
        chk("R9", "idle zero", {31'd0, zf}, 32'd1);
        chk("R8", "idle overflow", {31'd0, of}, 32'd0);
        chk("R7", "idle carry", {31'd0, cf}, 32'd0);

        for (int i = 0; i < 13; i++)
            apply_and_check(VEC[i][99:96], VEC[i][95:64], VEC[i][63:32], 1'b1, VEC[i][31:0]);

        // R5 with overflowing subtraction, both directions
        apply_and_check(4'b0111, 32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 32'd0);
        apply_and_check(4'b0111, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 32'd1);
        // R8 subtraction overflow, R7 carry on borrow-free subtract
        apply_and_check(4'b0110, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, 32'd0);
        apply_and_check(4'b0110, 32'h0000_0009, 32'h0000_0009, 1'b1, 32'd0);
        // R6 all-zero operands give all ones
        apply_and_check(4'b1100, 32'd0, 32'd0, 1'b1, 32'hFFFF_FFFF);

        for (int k = 0; k < 3000; k++) begin
            logic [3:0]  o;
            logic [31:0] x, y;
            case (k % 8)
                0: o = 4'b0000;
                1: o = 4'b0001;
                2: o = 4'b0010;
                3: o = 4'b0110;
                4: o = 4'b0111;
                5: o = 4'b1100;
                6: o = 4'b0111;
                default: o = 4'($urandom);
            endcase
            x = $urandom;
            y = (k % 5 == 0) ? x : $urandom;
            if (k % 7 == 0) x[31:30] = ~y[31:30];
            apply_and_check(o, x, y, 1'b0, 32'd0);
        end

        finish_run();
    end

endmodule